// File: doc/BRIEF.md
# Cache-Line Padded DMA Write Packer

This block sits between a receive datapath and the host-memory write path. It takes the bytes of one packet, one byte per accepted transfer, and places them into a single host receive buffer. That buffer can hold either the protocol headers or the application payload. The buffer's start address is given with the first byte of the packet. The block gathers the bytes into 64-byte lines. Each complete line is issued as one write request that carries a line address, 512 bits of data and a flag that marks the packet's final line.

A packet whose length is not a multiple of the line size ends in a partial line. The block fills the unused tail of that line with zero bytes and issues it as a full-line write, with every byte enable set. The host therefore never has to merge a partial line through a read-modify-write. Header-buffer packets and payload-buffer packets go through exactly the same path, and each write is tagged with the buffer kind. After the final line of a packet is accepted, the block emits a completion pulse that gives the true byte count, with the padding excluded. Bytes are always written in the order they arrive.

Top module: `cl_pad_packer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `wr_valid` and `done_valid` are low and `in_ready` is high.
- R2: Every write request covers one 64-byte line, and `wr_be` is all ones. Packet byte k of a line (k = 0..63, counted in arrival order) appears at `wr_data[8k+7:8k]`.
- R3: The first line of a packet is written to `in_base` with bits 5:0 cleared. `in_base` is sampled together with the packet's first byte. Each later line of the same packet goes to the previous line address plus 64.
- R4: The final line of a packet has `wr_last` = 1, and no other line does. In that final line, every byte position at or beyond the packet length holds 0x00.
- R5: A packet whose length is an exact multiple of 64 produces exactly length/64 writes, with no added padding line.
- R6: `done_valid` is high for exactly one cycle. That cycle is the one right after the clock edge at which the final line was accepted (`wr_valid`, `wr_ready` and `wr_last` all high). During it, `done_len` equals the real packet byte count.
- R7: While `wr_valid` is high and `wr_ready` is low, `wr_addr`, `wr_data` and `wr_last` stay unchanged and `in_ready` is low. A line becomes valid in the cycle after the edge that accepted the byte completing it.
- R8: `in_hdr`, sampled with the first byte, selects a header buffer (1) or a payload buffer (0). It does not change the padding, addressing or length reporting. It is reported on `wr_hdr` and `done_hdr` for every write and for the completion of that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte can be accepted |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Byte is the last of its packet |
| in_hdr | input | 1 | Packet goes to a header buffer (1) or a payload buffer (0) |
| in_base | input | ADDR_W | Buffer start address, sampled with the first byte |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | ADDR_W | Line-aligned write address |
| wr_data | output | 8*LINE_BYTES | Full line of data |
| wr_be | output | LINE_BYTES | Byte enables, always all ones |
| wr_last | output | 1 | Final line of the packet |
| wr_hdr | output | 1 | Buffer kind of this write |
| done_valid | output | 1 | Completion pulse |
| done_len | output | LEN_W | True packet length in bytes |
| done_hdr | output | 1 | Buffer kind of the completed packet |

## Verification
A line becomes valid one cycle after the edge that accepts the byte completing it. The completion pulse appears one cycle after the edge that accepts the final line. The bench drives inputs on falling edges and samples every result on the falling edge that follows the relevant rising edge. When it holds `wr_ready` low, it samples again on each stalled falling edge to confirm that the line is held and the input is stalled. It also samples one falling edge after the completion pulse to confirm that the pulse has ended.

// File: rtl/cl_pad_packer.sv
module cl_pad_packer #(
  parameter int LINE_BYTES = 64,
  parameter int ADDR_W     = 48,
  parameter int LEN_W      = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [7:0]              in_data,
  input  logic                    in_last,
  input  logic                    in_hdr,
  input  logic [ADDR_W-1:0]       in_base,
  output logic                    wr_valid,
  input  logic                    wr_ready,
  output logic [ADDR_W-1:0]       wr_addr,
  output logic [8*LINE_BYTES-1:0] wr_data,
  output logic [LINE_BYTES-1:0]   wr_be,
  output logic                    wr_last,
  output logic                    wr_hdr,
  output logic                    done_valid,
  output logic [LEN_W-1:0]        done_len,
  output logic                    done_hdr
);
  localparam int IDX_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = 8 * LINE_BYTES;

  logic [LINE_W-1:0] line_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic              active_q, last_q, hdr_q, wv_q, dv_q;

  wire take      = in_valid && in_ready;
  wire issue     = wv_q && wr_ready;
  wire line_full = (idx_q == IDX_W'(LINE_BYTES - 1));

  assign in_ready   = !wv_q;
  assign wr_valid   = wv_q;
  assign wr_addr    = addr_q;
  assign wr_data    = line_q;
  assign wr_be      = '1;
  assign wr_last    = last_q;
  assign wr_hdr     = hdr_q;
  assign done_valid = dv_q;
  assign done_len   = len_q;
  assign done_hdr   = hdr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q   <= '0;
      idx_q    <= '0;
      addr_q   <= '0;
      len_q    <= '0;
      active_q <= 1'b0;
      last_q   <= 1'b0;
      hdr_q    <= 1'b0;
      wv_q     <= 1'b0;
      dv_q     <= 1'b0;
    end else begin
      dv_q <= issue && last_q;
      if (take) begin
        line_q[idx_q*8 +: 8] <= in_data;
        if (!active_q) begin
          addr_q   <= in_base & ~ADDR_W'(LINE_BYTES - 1);
          hdr_q    <= in_hdr;
          len_q    <= LEN_W'(1);
          active_q <= 1'b1;
        end else begin
          len_q <= len_q + LEN_W'(1);
        end
        if (line_full || in_last) begin
          wv_q   <= 1'b1;
          last_q <= in_last;
          idx_q  <= '0;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end
      if (issue) begin
        wv_q   <= 1'b0;
        line_q <= '0;
        if (last_q) active_q <= 1'b0;
        else        addr_q   <= addr_q + ADDR_W'(LINE_BYTES);
      end
    end
  end
endmodule

// File: rtl/cl_pad_packer_chk.sv
module cl_pad_packer_chk #(
  parameter int LINE_BYTES = 64,
  parameter int ADDR_W     = 48
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_ready,
  input logic                    wr_valid,
  input logic                    wr_ready,
  input logic [ADDR_W-1:0]       wr_addr,
  input logic [8*LINE_BYTES-1:0] wr_data,
  input logic                    wr_last,
  input logic                    done_valid
);
  localparam int IDX_W = $clog2(LINE_BYTES);

  a_r7_hold_line: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_last));

  a_r7_stall_input: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !in_ready);

  a_r3_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_addr[IDX_W-1:0] == '0);

  a_r6_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> $past(wr_valid && wr_ready && wr_last));

  a_r6_last_gives_done: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && wr_last |=> done_valid);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);
endmodule

bind cl_pad_packer cl_pad_packer_chk #(.LINE_BYTES(LINE_BYTES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
  .wr_last(wr_last), .done_valid(done_valid)
);

// File: tb/tb_cl_pad_packer.sv
module tb_cl_pad_packer;
  localparam int LB = 64;
  localparam int AW = 48;
  localparam int LW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, in_hdr = 1'b0, wr_ready = 1'b0;
  logic [7:0] in_data = '0;
  logic [AW-1:0] in_base = '0;
  logic in_ready, wr_valid, wr_last, wr_hdr, done_valid, done_hdr;
  logic [AW-1:0] wr_addr;
  logic [8*LB-1:0] wr_data;
  logic [LB-1:0] wr_be;
  logic [LW-1:0] done_len;

  always #2.5 clk = ~clk;

  cl_pad_packer #(.LINE_BYTES(LB), .ADDR_W(AW), .LEN_W(LW)) dut (.*);

  typedef struct packed {
    logic [15:0] len;
    logic [47:0] base;
    logic        hdr;
    logic [3:0]  dly;
    logic [7:0]  seed;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{16'd86,  48'h0000_0000_1000, 1'b1, 4'd0, 8'h10},
    '{16'd64,  48'h0000_0000_2040, 1'b0, 4'd1, 8'h20},
    '{16'd1,   48'h0000_0000_3000, 1'b1, 4'd2, 8'hA5},
    '{16'd200, 48'h0000_4000_0000, 1'b0, 4'd0, 8'hF0},
    '{16'd128, 48'h0000_0000_5080, 1'b0, 4'd3, 8'h01},
    '{16'd63,  48'h0000_0000_6000, 1'b1, 4'd0, 8'h7E},
    '{16'd65,  48'h0000_0000_7013, 1'b0, 4'd1, 8'h33}
  };

  int checks = 0;
  int fails  = 0;
  bit done_flag = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [8*LB-1:0] act, input logic [8*LB-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_pkt(input vec_t v);
    int nlines = (int'(v.len) + LB - 1) / LB;
    logic [AW-1:0] a0 = v.base & ~AW'(LB - 1);
    for (int ln = 0; ln < nlines; ln++) begin
      logic [8*LB-1:0] exp_d = '0;
      int nb = (ln == nlines - 1) ? int'(v.len) - ln * LB : LB;
      for (int j = 0; j < LB; j++)
        if (j < nb) exp_d[8*j +: 8] = v.seed + 8'(ln * LB + j);
      for (int j = 0; j < nb; j++) begin
        in_valid = 1'b1;
        in_data  = v.seed + 8'(ln * LB + j);
        in_last  = (ln == nlines - 1) && (j == nb - 1);
        in_hdr   = v.hdr;
        in_base  = v.base;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_hdr   = ~v.hdr;
        in_base  = '1;
      end
      chk(wr_valid == 1'b1, "R7 line valid after completing byte", 512'(wr_valid), 512'(1));
      chk(wr_addr == a0 + AW'(ln * LB), "R3 line address", 512'(wr_addr), 512'(a0 + AW'(ln * LB)));
      chk(wr_data == exp_d, "R2/R4 line data and zero pad", wr_data, exp_d);
      chk(&wr_be, "R2 all byte enables", 512'(wr_be), 512'({LB{1'b1}}));
      chk(wr_last == (ln == nlines - 1), "R4 R5 last flag", 512'(wr_last), 512'(ln == nlines - 1));
      chk(wr_hdr == v.hdr, "R8 buffer kind on write", 512'(wr_hdr), 512'(v.hdr));
      for (int d = 0; d < int'(v.dly); d++) begin
        @(posedge clk);
        @(negedge clk);
        chk(wr_valid && !in_ready && wr_data == exp_d, "R7 held while stalled", wr_data, exp_d);
      end
      wr_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr_ready = 1'b0;
      chk(wr_valid == 1'b0 && in_ready, "R7 line released", 512'(wr_valid), 512'(0));
      if (ln == nlines - 1) begin
        chk(done_valid == 1'b1, "R6 completion pulse", 512'(done_valid), 512'(1));
        chk(done_len == v.len, "R6 true length", 512'(done_len), 512'(v.len));
        chk(done_hdr == v.hdr, "R8 buffer kind on completion", 512'(done_hdr), 512'(v.hdr));
        @(posedge clk);
        @(negedge clk);
        chk(done_valid == 1'b0, "R6 single cycle pulse", 512'(done_valid), 512'(0));
      end else begin
        chk(done_valid == 1'b0, "R6 no completion mid packet", 512'(done_valid), 512'(0));
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!wr_valid && !done_valid && in_ready, "R1 in reset", 512'({wr_valid, done_valid, in_ready}), 512'(3'b001));
    rst_n = 1'b1;
    @(negedge clk);
    chk(!wr_valid && !done_valid && in_ready, "R1 after reset", 512'({wr_valid, done_valid, in_ready}), 512'(3'b001));
    foreach (VECS[i]) send_pkt(VECS[i]);
    // directed: idle cycles with in_valid low produce nothing (R7)
    repeat (5) @(negedge clk);
    chk(!wr_valid && !done_valid, "R7 idle produces no write", 512'(wr_valid), 512'(0));
    // directed: two exact-multiple packets back to back (R5)
    send_pkt('{16'd64, 48'h0000_0000_8000, 1'b1, 4'd0, 8'h00});
    send_pkt('{16'd192, 48'h0000_0000_9000, 1'b0, 4'd2, 8'hC3});
    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule